// File: doc/BRIEF.md
# Transport Stream System Time Clock Counter

This block holds and advances the 42-bit time base of a transport stream receiver. The count has two fields. A 9-bit extension advances on each 27 MHz tick and counts 0 to 299. Each time it wraps, it carries into a 33-bit base, which therefore advances at 90 kHz. A strobe input `tick` marks each 27 MHz period, so one enabled cycle is one tick.

Software uses a simple single-cycle register bus with a word address, a write strobe and a combinational read path. It loads a start value through a split initialization pair, and a write to either half reloads the whole count. It reads the running value through two status words. Because the count keeps moving between two reads, software can read the low word twice to get a consistent value.

A 42-bit compare value and an enable bit drive a sticky match flag, which is also the interrupt output. Software clears the enable before reloading the count, so that the reload cannot raise a false match.

Register map (word addresses): 0 INIT_LO, 1 INIT_HI, 2 STAT_LO, 3 STAT_HI, 4 CTRL, 5 CMP_LO, 6 CMP_HI, 7 FLAG.

Top module: `stc_counter`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: INIT_HI (address 1) holds the extension load value in bits 9..1 and the load value for base bit 32 in bit 0. Bits 31..10 always read 0, and writing them has no effect.
- R3: A write to INIT_LO (address 0, base bits 31..0) or to INIT_HI reloads the base and the extension together, in the cycle after the write. The half being written supplies the new data, and the other half supplies its stored value.
- R4: On each `tick`, the extension advances by one while it is below 299. When the extension is 299 or more, a tick sets it to 0 and increments the base.
- R5: The base wraps modulo 2^33, so {base bit 32 = 1, base bits 31..0 = all ones, extension 299} goes to 0 on one tick.
- R6: STAT_LO (address 2) returns base bits 31..0. STAT_HI (address 3) returns base bit 32 in bit 0 and the extension in bits 9..1, with the other bits read as 0. Writes to either status register have no effect.
- R7: When an initialization write and a `tick` fall in the same cycle, the count takes the loaded value and does not advance.
- R8: While CTRL bit 0 is 1, FLAG bit 0 sets in the cycle after the count equals the compare value. CMP_LO (address 5) holds base bits 31..0, and CMP_HI (address 6) holds bit 32 in bit 0 and the extension in bits 9..1. While CTRL bit 0 is 0, a match does not set the flag.
- R9: The flag stays set until software writes 1 to FLAG bit 0 (address 7). Writing 0 leaves it set. `irq` follows the flag.
- R10: When a write-1 clear and an enabled match fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 27 MHz tick strobe |
| addr | input | 3 | Register word address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Sticky compare-match interrupt |

## Verification
Two pairs of events can land in the same cycle. The first pair is a reload and a tick. The bench drives an INIT_LO write with `tick` high and expects the status words to show exactly the loaded value, with no extra extension step. The second pair is a flag clear and a new match. The bench parks the count on the compare value with the enable set, writes 1 to FLAG, and expects the flag to read 1. It then clears the enable and expects the same write to clear the flag.

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int BASE_W  = 33,
  parameter int EXT_W   = 9,
  parameter int EXT_MOD = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [2:0]  addr,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int HI_W = BASE_W - 32;
  localparam int HW   = EXT_W + HI_W;

  logic [31:0]       init_lo, cmp_lo;
  logic [HW-1:0]     init_hi, cmp_hi;
  logic [BASE_W-1:0] base;
  logic [EXT_W-1:0]  ext;
  logic              en, flag;

  wire wr_ilo  = we && addr == 3'd0;
  wire wr_ihi  = we && addr == 3'd1;
  wire init_wr = wr_ilo || wr_ihi;
  wire [31:0]   ld_lo = wr_ilo ? wdata : init_lo;
  wire [HW-1:0] ld_hi = wr_ihi ? wdata[HW-1:0] : init_hi;
  wire [HW-1:0] cur_hi = {ext, base[BASE_W-1:32]};
  wire match = en && base[31:0] == cmp_lo && cur_hi == cmp_hi;
  wire clr   = we && addr == 3'd7 && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_lo <= '0; init_hi <= '0; cmp_lo <= '0; cmp_hi <= '0;
      en <= 1'b0;
    end else if (we) begin
      case (addr)
        3'd0: init_lo <= wdata;
        3'd1: init_hi <= wdata[HW-1:0];
        3'd4: en      <= wdata[0];
        3'd5: cmp_lo  <= wdata;
        3'd6: cmp_hi  <= wdata[HW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      ext  <= '0;
    end else if (init_wr) begin
      base <= {ld_hi[HI_W-1:0], ld_lo};
      ext  <= ld_hi[HW-1:HI_W];
    end else if (tick) begin
      if (ext >= EXT_W'(EXT_MOD - 1)) begin
        ext  <= '0;
        base <= base + 1'b1;
      end else begin
        ext <= ext + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (match) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag;

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata = init_lo;
      3'd1: rdata[HW-1:0] = init_hi;
      3'd2: rdata = base[31:0];
      3'd3: rdata[HW-1:0] = cur_hi;
      3'd4: rdata[0] = en;
      3'd5: rdata = cmp_lo;
      3'd6: rdata[HW-1:0] = cmp_hi;
      default: rdata[0] = flag;
    endcase
  end

  always_comb if (addr == 3'd1 || addr == 3'd3) p_reserved_zero_r2: assert (rdata[31:HW] == '0);

  p_reload_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ilo |=> base[31:0] == $past(wdata));
  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !init_wr && ext == EXT_W'(EXT_MOD - 1)) |=> ext == '0 && base == $past(base) + 1'b1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_wr) |=> $stable(ext) && $stable(base));
  p_set_only_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !$rose(flag));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: tb/stc_counter_test.sv
module stc_counter_test;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int tests = 0, fails = 0;

  stc_counter uut (.clk, .rst_n, .tick, .addr, .we, .wdata, .rdata, .irq);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic t = 0);
    @(negedge clk); addr = a; wdata = d; we = 1; tick = t;
    @(negedge clk); we = 0; tick = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  function automatic logic [31:0] hi(int e, bit m);
    return (32'(e) << 1) | 32'(m);
  endfunction

  task automatic load(logic [31:0] lo, int e, bit m);
    wr(3'd1, hi(e, m));
    wr(3'd0, lo);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    load(32'h1234_5678, 5, 1);
    rd(3'd2, d); chk("R3 lo", d, 32'h1234_5678);
    rd(3'd3, d); chk("R6 hi", d, hi(5, 1));
    wr(3'd1, hi(7, 0));
    rd(3'd2, d); chk("R3 hi-write keeps lo", d, 32'h1234_5678);
    rd(3'd3, d); chk("R3 hi-write", d, hi(7, 0));
    wr(3'd2, 32'hdead_beef);
    rd(3'd2, d); chk("R6 stat ro", d, 32'h1234_5678);
  endtask

  task automatic t_count;
    logic [31:0] d;
    load(32'd10, 297, 0);
    ticks(5);
    rd(3'd2, d); chk("R4 carry base", d, 11);
    rd(3'd3, d); chk("R4 ext", d, hi(2, 0));
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    load(32'hffff_ffff, 299, 1);
    ticks(1);
    rd(3'd2, d); chk("R5 lo", d, 0);
    rd(3'd3, d); chk("R5 hi", d, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(3'd0, 32'd40);
    wr(3'd1, 32'hffff_ffff);
    rd(3'd1, d); chk("R2 reserved", d, 32'h3ff);
    rd(3'd3, d); chk("R2 fields", d, 32'h3ff);
    ticks(1);
    rd(3'd3, d); chk("R4 over-range wrap", d, hi(0, 1));
    rd(3'd2, d); chk("R4 over-range base", d, 41);
  endtask

  task automatic t_coincide;
    logic [31:0] d;
    wr(3'd1, hi(20, 0));
    wr(3'd0, 32'd100, 1);
    rd(3'd2, d); chk("R7 lo", d, 100);
    rd(3'd3, d); chk("R7 ext", d, hi(20, 0));
  endtask

  task automatic t_compare;
    logic [31:0] d;
    wr(3'd5, 32'd50); wr(3'd6, hi(2, 0)); wr(3'd4, 0);
    load(32'd50, 0, 0);
    ticks(3); @(negedge clk);
    rd(3'd7, d); chk("R8 disabled", d, 0);
    wr(3'd4, 1);
    load(32'd50, 0, 0);
    ticks(2); @(negedge clk);
    rd(3'd7, d); chk("R8 match", d, 1);
    chk("R9 irq", {31'b0, irq}, 1);
    wr(3'd4, 0);
    ticks(4);
    rd(3'd7, d); chk("R9 sticky", d, 1);
    wr(3'd7, 0);
    rd(3'd7, d); chk("R9 write0", d, 1);
    wr(3'd7, 1);
    rd(3'd7, d); chk("R9 w1c", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    load(32'd50, 2, 0);
    wr(3'd4, 1);
    @(negedge clk);
    wr(3'd7, 1);
    rd(3'd7, d); chk("R10 set wins", d, 1);
    wr(3'd4, 0);
    wr(3'd7, 1);
    rd(3'd7, d); chk("R10 clear after disable", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_load; t_count; t_wrap; t_reserved; t_coincide; t_compare; t_race;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule